// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block produces the reset for a processor from three causes: a supply-undervoltage flag from an outside comparator, a manual-reset request, and a watchdog that fires when software stops toggling its kick pin. Any cause pulls the reset low at once. After the last cause has gone away, the reset stays low for a fixed hold interval. The block drives an active-low reset and an active-high copy of it.

All three inputs may be asynchronous to the block clock, and each passes through a two-flop synchronizer. Time is counted in ticks from a prescaler that divides the system clock. The hold interval and the watchdog timeout are parameters given in ticks. With the defaults (1 MHz clock, 1 ms tick), they are 200 ms and 1.6 s. No input can switch the watchdog off.

Top module: `rst_supervisor`

## Requirements
- R1: While the synchronous system reset `rst` is high, `rst_n_o` is 0. After `rst` falls with no cause present, `rst_n_o` rises exactly 2 + HOLD_TICKS*TICK_DIV clocks after the first clock edge that samples `rst` low.
- R2: When `uv_i` goes to 1, `rst_n_o` goes low on the third clock edge after the change.
- R3: Reset is released HOLD_TICKS*TICK_DIV clocks after the synchronized causes have all cleared, counted from the second clock edge after the last cause releases. Each new undervoltage dip during the hold restarts the interval from zero. When causes overlap, the release that comes last sets the timing.
- R4: When `mr_n_i` goes to 0, reset asserts on the third clock edge. Reset stays asserted while `mr_n_i` is 0, and then for the full hold interval after `mr_n_i` returns to 1.
- R5: When the synchronized kick shows no edge for WDOG_TICKS*TICK_DIV clocks while reset is released, reset asserts and then releases after HOLD_TICKS*TICK_DIV clocks.
- R6: A rising edge or a falling edge on `kick_i` restarts the watchdog. The timeout is then counted from the third clock edge after the kick changes.
- R7: The watchdog is held cleared while reset is asserted, and kick edges during that time have no effect. It starts counting from the clock edge at which reset releases. With a static kick, reset therefore recurs with a period of (WDOG_TICKS + HOLD_TICKS)*TICK_DIV clocks, and no input disables it.
- R8: `rst_o` is always the logical inverse of `rst_n_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous system reset, active high |
| uv_i | input | 1 | Supply-undervoltage flag, 1 = supply low (asynchronous) |
| mr_n_i | input | 1 | Manual reset request, active low (asynchronous) |
| kick_i | input | 1 | Watchdog kick; either edge restarts the watchdog (asynchronous) |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high, inverse of rst_n_o |

## Verification
The assertions watch the synchronizer outputs, not the raw pins. They assume that each input level, once seen after synchronization, is what the cause logic acts on. So an input only needs to be stable for the synchronizer to capture it. The stimulus changes inputs only on falling clock edges and holds every level for at least two clocks, so each change reaches the synchronized side with no metastable ambiguity and with a known latency. Every kick is placed inside the watchdog window, so that the exact release and expiry cycles can be predicted.

// File: rtl/sup_pkg.sv
package sup_pkg;
  // Raw or synchronized view of the three asynchronous causes
  typedef struct packed {
    logic uv;    // 1 = supply below threshold
    logic mr_n;  // 0 = manual reset requested
    logic kick;  // watchdog kick level
  } sup_in_t;

  // Safe values held in the synchronizers during system reset
  localparam sup_in_t SYNC_RST_VAL = '{uv: 1'b1, mr_n: 1'b1, kick: 1'b0};
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= RST_VAL;
      s2 <= RST_VAL;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q = s2;
endmodule

// File: rtl/sup_tick.sv
module sup_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV < 2) ? 1 : $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = !clr && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sup_hold.sv
module sup_hold #(
  parameter int HOLD_TICKS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic tick,
  output logic asserted,
  output logic [$clog2(HOLD_TICKS+1)-1:0] cnt
);
  localparam int HCW = $clog2(HOLD_TICKS + 1);
  localparam logic [HCW-1:0] LAST = HCW'(HOLD_TICKS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      asserted <= 1'b1;
      cnt      <= '0;
    end else if (trig) begin
      asserted <= 1'b1;
      cnt      <= '0;
    end else if (asserted && tick) begin
      if (cnt == LAST) begin
        asserted <= 1'b0;
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
  parameter int WDOG_TICKS = 1600
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic kick_edge,
  input  logic tick,
  output logic expire,
  output logic [$clog2(WDOG_TICKS+1)-1:0] cnt
);
  localparam int WCW = $clog2(WDOG_TICKS + 1);
  localparam logic [WCW-1:0] LAST = WCW'(WDOG_TICKS - 1);

  assign expire = tick && !hold && !kick_edge && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || hold || kick_edge || expire) cnt <= '0;
    else if (tick)                          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import sup_pkg::*;
#(
  parameter int TICK_DIV   = 1000,
  parameter int HOLD_TICKS = 200,
  parameter int WDOG_TICKS = 1600
) (
  input  logic clk,
  input  logic rst,
  input  logic uv_i,
  input  logic mr_n_i,
  input  logic kick_i,
  output logic rst_n_o,
  output logic rst_o
);
  localparam int HCW = $clog2(HOLD_TICKS + 1);
  localparam int WCW = $clog2(WDOG_TICKS + 1);
  localparam int NPRE = 2;  // 0: hold timer, 1: watchdog

  sup_in_t raw, synced;
  logic    uv_sync, mr_sync, kick_prev, kick_edge;
  logic    trig, asserted, wd_expire;
  logic [NPRE-1:0] pre_clr, pre_tick;
  logic [HCW-1:0]  hold_cnt;
  logic [WCW-1:0]  wd_cnt;

  assign raw = '{uv: uv_i, mr_n: mr_n_i, kick: kick_i};

  sup_sync #(.W($bits(sup_in_t)), .RST_VAL(SYNC_RST_VAL)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(synced)
  );

  assign uv_sync = synced.uv;
  assign mr_sync = synced.mr_n;

  always_ff @(posedge clk) begin
    if (rst) kick_prev <= SYNC_RST_VAL.kick;
    else     kick_prev <= synced.kick;
  end
  assign kick_edge = synced.kick ^ kick_prev;

  assign trig = uv_sync || !mr_sync || wd_expire;

  // Each timer owns a prescaler that restarts with it, so its phase is exact
  assign pre_clr[0] = trig;
  assign pre_clr[1] = asserted || kick_edge;

  for (genvar g = 0; g < NPRE; g++) begin : g_pre
    sup_tick #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst(rst), .clr(pre_clr[g]), .tick(pre_tick[g])
    );
  end

  sup_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .rst(rst), .trig(trig), .tick(pre_tick[0]),
    .asserted(asserted), .cnt(hold_cnt)
  );

  sup_wdog #(.WDOG_TICKS(WDOG_TICKS)) u_wdog (
    .clk(clk), .rst(rst), .hold(asserted), .kick_edge(kick_edge),
    .tick(pre_tick[1]), .expire(wd_expire), .cnt(wd_cnt)
  );

  assign rst_n_o = !asserted;
  assign rst_o   = asserted;
endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk #(
  parameter int HOLD_TICKS = 200,
  parameter int WDOG_TICKS = 1600
) (
  input logic clk,
  input logic rst,
  input logic rst_n_o,
  input logic rst_o,
  input logic uv_sync,
  input logic mr_sync,
  input logic kick_edge,
  input logic wd_expire,
  input logic [$clog2(HOLD_TICKS+1)-1:0] hold_cnt,
  input logic [$clog2(WDOG_TICKS+1)-1:0] wd_cnt
);
  localparam int HCW = $clog2(HOLD_TICKS + 1);
  localparam logic [HCW-1:0] HMAX = HCW'(HOLD_TICKS);

  AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (rst) rst_o == !rst_n_o); // R8
  AST_UV_ASSERTS: assert property (@(posedge clk) disable iff (rst) uv_sync |=> !rst_n_o); // R2
  AST_MR_ASSERTS: assert property (@(posedge clk) disable iff (rst) !mr_sync |=> !rst_n_o); // R4
  AST_HOLD_RANGE: assert property (@(posedge clk) disable iff (rst) hold_cnt < HMAX); // R3
  AST_RELEASE_CLEAN: assert property (@(posedge clk) disable iff (rst) $rose(rst_n_o) |-> $past(!uv_sync && mr_sync)); // R3
  AST_WD_FIRES: assert property (@(posedge clk) disable iff (rst) wd_expire |=> !rst_n_o); // R5
  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (rst) kick_edge |=> wd_cnt == '0); // R6
  AST_WD_HELD: assert property (@(posedge clk) disable iff (rst) !rst_n_o |=> wd_cnt == '0); // R7
endmodule

bind rst_supervisor rst_supervisor_chk #(
  .HOLD_TICKS(HOLD_TICKS), .WDOG_TICKS(WDOG_TICKS)
) u_chk (
  .clk(clk), .rst(rst), .rst_n_o(rst_n_o), .rst_o(rst_o),
  .uv_sync(uv_sync), .mr_sync(mr_sync), .kick_edge(kick_edge),
  .wd_expire(wd_expire), .hold_cnt(hold_cnt), .wd_cnt(wd_cnt)
);

// File: tb/rst_supervisor_bench.sv
module rst_supervisor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 4;
  localparam int HOLD = 5;
  localparam int WD   = 8;
  localparam int HOLD_CYC = HOLD * DIV;
  localparam int WD_CYC   = WD * DIV;
  localparam int WATCHDOG_CYC = 5000;

  typedef struct {
    int    cyc;
    bit    lvl;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst, uv, mr_n, kick;
  logic rst_n_o, rst_o;
  int   cyc = 0;
  int   total = 0, bad = 0;
  bit   mon_en = 0, done = 0;
  logic prev_n = 1'b0;
  exp_t q[$];
  exp_t e;

  rst_supervisor #(.TICK_DIV(DIV), .HOLD_TICKS(HOLD), .WDOG_TICKS(WD)) u_rst_supervisor (
    .clk(clk), .rst(rst), .uv_i(uv), .mr_n_i(mr_n), .kick_i(kick),
    .rst_n_o(rst_n_o), .rst_o(rst_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  task automatic push(int c, bit l, string r);
    exp_t x;
    x.cyc = c; x.lvl = l; x.req = r;
    q.push_back(x);
  endtask

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Monitor: pops the expected edge each time the reset output moves
  always @(negedge clk) begin
    if (mon_en) begin
      if (rst_n_o !== prev_n) begin
        if (q.size() == 0) begin
          check(1'b0, "R3", "unexpected reset edge at cycle", cyc, -1);
        end else begin
          e = q.pop_front();
          check(rst_n_o === e.lvl, e.req, "reset level", int'(rst_n_o), int'(e.lvl));
          check(cyc == e.cyc, e.req, "edge cycle", cyc, e.cyc);
          check(rst_o === ~rst_n_o, "R8", "rst_o vs rst_n_o", int'(rst_o), int'(~rst_n_o));
        end
        prev_n = rst_n_o;
      end else if (rst_o !== ~rst_n_o) begin
        check(1'b0, "R8", "rst_o vs rst_n_o", int'(rst_o), int'(~rst_n_o));
      end
    end
  end

  initial begin
    int n, k, last;
    rst = 1'b1; uv = 1'b0; mr_n = 1'b1; kick = 1'b0;
    repeat (3) @(negedge clk);
    check(rst_n_o === 1'b0, "R1", "rst_n_o during system reset", int'(rst_n_o), 0);
    check(rst_o === 1'b1, "R1", "rst_o during system reset", int'(rst_o), 1);

    // R1: power-on release
    rst = 1'b0; n = cyc;
    last = n + 2 + HOLD_CYC;
    push(last, 1'b1, "R1");
    mon_en = 1;

    // R5 / R7: static kick gives periodic resets
    for (int i = 0; i < 2; i++) begin
      push(last + WD_CYC, 1'b0, "R5");
      push(last + WD_CYC + HOLD_CYC, 1'b1, "R7");
      last = last + WD_CYC + HOLD_CYC;
    end
    wait_to(last + 1);

    // R6: rising then falling kick each restart the watchdog
    wait_to(last + 20);
    kick = 1'b1; k = cyc + 3;
    wait_to(k + 25);
    kick = 1'b0; k = cyc + 3;
    push(k + WD_CYC, 1'b0, "R6");
    push(k + WD_CYC + HOLD_CYC, 1'b1, "R6");
    last = k + WD_CYC + HOLD_CYC;
    wait_to(last + 1);

    // R2 / R3: undervoltage, long hold, then a dip that restarts the interval
    wait_to(last + 5);
    uv = 1'b1; n = cyc;
    push(n + 3, 1'b0, "R2");
    wait_to(n + 50);
    uv = 1'b0;
    wait_to(cyc + 10);
    uv = 1'b1;
    wait_to(cyc + 2);
    uv = 1'b0; n = cyc;
    last = n + 2 + HOLD_CYC;
    push(last, 1'b1, "R3");
    wait_to(last + 1);

    // R4 / R7: manual reset, with kick edges while held that must be ignored
    wait_to(last + 5);
    mr_n = 1'b0; n = cyc;
    push(n + 3, 1'b0, "R4");
    wait_to(n + 10); kick = 1'b1;
    wait_to(n + 20); kick = 1'b0;
    wait_to(n + 40);
    mr_n = 1'b1; n = cyc;
    last = n + 2 + HOLD_CYC;
    push(last, 1'b1, "R4");
    wait_to(last + 1);

    // R3: overlapping causes, undervoltage released last
    wait_to(last + 5);
    mr_n = 1'b0; n = cyc;
    push(n + 3, 1'b0, "R4");
    wait_to(n + 6);  uv = 1'b1;
    wait_to(n + 15); mr_n = 1'b1;
    wait_to(n + 25); uv = 1'b0;
    last = cyc + 2 + HOLD_CYC;
    push(last, 1'b1, "R3");

    // R7: watchdog counts from release again
    push(last + WD_CYC, 1'b0, "R7");
    push(last + WD_CYC + HOLD_CYC, 1'b1, "R7");
    last = last + WD_CYC + HOLD_CYC;
    wait_to(last + 3);

    check(q.size() == 0, "R5", "expected edges left unseen", q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 run did not complete: actual=%0d expected=%0d", cyc, WATCHDOG_CYC);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule